// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the system reset for a chip from two sources. The first is a digital supply-good flag from an external voltage comparator. While that flag is low, reset is held. Once the flag returns high, reset is held for a further fixed timeout. The second source is an active-low manual reset button.

A falling edge on the button, seen while the block is idle, produces one reset pulse of the same fixed timeout. The length of the pulse does not depend on how long the button is held. After the pulse comes a lockout window in which the button is ignored. After the lockout, the button has to be seen released and then pressed again before another pulse can start.

Both inputs pass through two-flop synchronizers. A single shared down-counter times the supply timeout, the manual pulse and the lockout. Reset is driven at two registered outputs of opposite polarity. Every interval is a parameter counted in clock cycles. The defaults are 800 ms of timeout and 80 µs of lockout at 125 MHz.

Top module: `reset_supervisor`

## Requirements
- R1: While `rst` is high, and in every cycle after it while the synchronized supply flag is low, reset is asserted (`rst_o`=1, `rst_n_o`=0). The first clock edge with `rst` high already gives this state.
- R2: A rise of `supply_ok_i` with the button idle releases reset exactly `TIMEOUT_CYC`+3 clock edges after the input changes: two edges of synchronization, one edge to start the timeout, then `TIMEOUT_CYC` edges of timeout.
- R3: A falling edge of `mr_n_i` in the idle state asserts reset 3 edges after the fall. Reset stays asserted for exactly `TIMEOUT_CYC` cycles. It then clears even if `mr_n_i` is still low.
- R4: Holding `mr_n_i` low after a manual pulse causes no further pulse.
- R5: For `LOCKOUT_CYC` cycles after a manual pulse ends, falling edges on `mr_n_i` are ignored and reset stays released.
- R6: A new manual pulse needs `mr_n_i` to be seen high while idle (after the lockout) and then low. A button already low when the idle state is entered gives no pulse.
- R7: A low supply flag overrides a manual pulse or a lockout. Reset is asserted 3 edges after the flag falls. When the flag recovers, a full `TIMEOUT_CYC` timeout is applied again.
- R8: `rst_n_o` is always the complement of `rst_o`. `rst_o`=1 means reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on clear; forces the supply-low state |
| supply_ok_i | input | 1 | 1 = supply above threshold, 0 = supply below threshold (asynchronous) |
| mr_n_i | input | 1 | Manual reset button, active low, 1 when unused (asynchronous) |
| rst_n_o | output | 1 | Active-low system reset, registered |
| rst_o | output | 1 | Active-high system reset, registered |

## Verification
A wrong state or a wrong counter value in this block shows up as a reset edge on the wrong cycle. It can also show up as a pulse that should not exist, or as a missing pulse. Each release edge is therefore checked on its exact cycle, together with the cycle just before it. The cases that expose a stuck re-arm flag or a missing lockout are a button held through the pulse, a button pressed during the lockout, and a button held across the end of the lockout. These show as a stray pulse within 3 cycles of the offending input. Dropping the supply during the pulse and during the lockout shows whether the supply takes priority and whether the timeout restarts in full. In those cases a wrong restart moves the release edge by many cycles.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  typedef enum logic [2:0] {
    S_SUPPLY_LOW = 3'd0,
    S_TIMEOUT    = 3'd1,
    S_IDLE       = 3'd2,
    S_MR_PULSE   = 3'd3,
    S_MR_LOCKOUT = 3'd4
  } rsup_state_e;
endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= RST_VAL;
          else     chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RST_VAL;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsup_arm.sv
module rsup_arm (
  input  logic clk,
  input  logic rst,
  input  logic idle_i,
  input  logic mr_s_i,
  output logic trig_o
);
  logic armed_q;

  // Armed only after the button is seen released while idle; cleared when a pulse fires.
  assign trig_o = idle_i && armed_q && !mr_s_i;

  always_ff @(posedge clk) begin
    if (rst)                  armed_q <= 1'b0;
    else if (trig_o)          armed_q <= 1'b0;
    else if (!idle_i)         armed_q <= 1'b0;
    else if (mr_s_i)          armed_q <= 1'b1;
  end

  // R6
  armed_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(idle_i && mr_s_i));

  // R4
  fire_once_chk: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !armed_q);
endmodule

// File: rtl/rsup_ctrl.sv
module rsup_ctrl
  import rsup_pkg::*;
#(
  parameter int TIMEOUT_CYC = 100_000_000,
  parameter int LOCKOUT_CYC = 10_000
) (
  input  logic clk,
  input  logic rst,
  input  logic sok_i,
  input  logic trig_i,
  output logic idle_o,
  output logic rst_o,
  output logic rst_n_o
);
  localparam int MAXC = (TIMEOUT_CYC > LOCKOUT_CYC) ? TIMEOUT_CYC : LOCKOUT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] T_LOAD = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] L_LOAD = CW'(LOCKOUT_CYC - 1);

  rsup_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_q, rst_n_q, rst_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!sok_i) begin
      state_d = S_SUPPLY_LOW;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        S_SUPPLY_LOW: begin
          state_d = S_TIMEOUT;
          cnt_d   = T_LOAD;
        end
        S_TIMEOUT: begin
          if (cnt_q == '0) state_d = S_IDLE;
          else             cnt_d   = cnt_q - 1'b1;
        end
        S_IDLE: begin
          if (trig_i) begin
            state_d = S_MR_PULSE;
            cnt_d   = T_LOAD;
          end
        end
        S_MR_PULSE: begin
          if (cnt_q == '0) begin
            state_d = S_MR_LOCKOUT;
            cnt_d   = L_LOAD;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        S_MR_LOCKOUT: begin
          if (cnt_q == '0) state_d = S_IDLE;
          else             cnt_d   = cnt_q - 1'b1;
        end
        default: begin
          state_d = S_SUPPLY_LOW;
          cnt_d   = '0;
        end
      endcase
    end
  end

  assign rst_d = (state_d == S_SUPPLY_LOW) || (state_d == S_TIMEOUT) ||
                 (state_d == S_MR_PULSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_SUPPLY_LOW;
      cnt_q   <= '0;
      rst_q   <= 1'b1;
      rst_n_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rst_q   <= rst_d;
      rst_n_q <= !rst_d;
    end
  end

  assign idle_o  = (state_q == S_IDLE);
  assign rst_o   = rst_q;
  assign rst_n_o = rst_n_q;

  // R1
  supply_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sok_i |=> rst_q);

  // R2
  timeout_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == S_TIMEOUT) |-> cnt_q == T_LOAD);

  // R3
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_MR_PULSE && sok_i && cnt_q != '0) |=> (state_q == S_MR_PULSE && rst_q));

  // R5
  lockout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_MR_LOCKOUT && sok_i) |=> (!rst_q && state_q != S_MR_PULSE));

  // R5
  lockout_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == S_MR_LOCKOUT) |-> $past(state_q) == S_MR_PULSE);
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int TIMEOUT_CYC = 100_000_000,
  parameter int LOCKOUT_CYC = 10_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic mr_n_i,
  output logic rst_n_o,
  output logic rst_o
);
  logic sok_s, mr_s, idle, trig;

  rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sok (
    .clk(clk), .rst(rst), .d_i(supply_ok_i), .q_o(sok_s)
  );

  rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mr (
    .clk(clk), .rst(rst), .d_i(mr_n_i), .q_o(mr_s)
  );

  rsup_arm u_arm (
    .clk(clk), .rst(rst), .idle_i(idle), .mr_s_i(mr_s), .trig_o(trig)
  );

  rsup_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC), .LOCKOUT_CYC(LOCKOUT_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .sok_i(sok_s), .trig_i(trig),
    .idle_o(idle), .rst_o(rst_o), .rst_n_o(rst_n_o)
  );

  // R8
  polarity_chk: assert property (@(posedge clk) disable iff (rst)
    rst_o != rst_n_o);
endmodule

// File: tb/reset_supervisor_tb.sv
module reset_supervisor_tb;
  localparam int T = 20;
  localparam int L = 8;

  typedef struct {
    int    cyc;
    logic  exp;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic mr_n = 1'b1;   // open pin modelled as logic 1
  logic rst_n_o, rst_o;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  item_t q[$];

  reset_supervisor #(.TIMEOUT_CYC(T), .LOCKOUT_CYC(L), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .mr_n_i(mr_n),
    .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int c, input logic e, input string r);
    item_t it;
    it.cyc = c; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop and compare at the scheduled cycle (after negedge, away from posedge)
  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.cyc != cyc || rst_o !== it.exp || rst_n_o !== !it.exp) begin
        errors++;
        $display("FAIL %s cyc=%0d: rst_o=%b rst_n_o=%b expected rst_o=%b rst_n_o=%b (sched %0d)",
                 it.req, cyc, rst_o, rst_n_o, it.exp, !it.exp, it.cyc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c;
    // R1: asserted during power-on clear
    expect_at(1, 1'b1, "R1");
    expect_at(2, 1'b1, "R1");
    wait_cyc(3);
    rst = 1'b0;
    expect_at(cyc + 8, 1'b1, "R1");
    wait_cyc(10);

    // R2: supply recovery timeout
    c = cyc; supply_ok = 1'b1;
    expect_at(c + T + 2, 1'b1, "R2");
    expect_at(c + T + 3, 1'b0, "R2");
    wait_cyc(T + 10);

    // R3 / R4: held button gives one fixed pulse
    c = cyc; mr_n = 1'b0;
    expect_at(c + 2, 1'b0, "R3");
    expect_at(c + 3, 1'b1, "R3");
    expect_at(c + T + 2, 1'b1, "R3");
    expect_at(c + T + 3, 1'b0, "R3");
    expect_at(c + 45, 1'b0, "R4");
    wait_cyc(50); mr_n = 1'b1;
    wait_cyc(20);

    // R5: press inside lockout ignored
    c = cyc; mr_n = 1'b0;
    expect_at(c + T + 3, 1'b0, "R3");
    expect_at(c + T + 15, 1'b0, "R5");
    expect_at(c + T + 25, 1'b0, "R5");
    wait_cyc(5); mr_n = 1'b1;
    wait_cyc(T); mr_n = 1'b0;
    wait_cyc(2); mr_n = 1'b1;
    wait_cyc(30);

    // R6: held through end of lockout gives no pulse; release then press re-arms
    c = cyc; mr_n = 1'b0;
    expect_at(c + 3, 1'b1, "R3");
    expect_at(c + T + L + 9, 1'b0, "R6");
    wait_cyc(T + L + 15); mr_n = 1'b1;
    wait_cyc(10);
    c = cyc; mr_n = 1'b0;
    expect_at(c + 2, 1'b0, "R6");
    expect_at(c + 3, 1'b1, "R6");
    wait_cyc(5); mr_n = 1'b1;
    wait_cyc(T + 10);

    // R7: supply drop during manual pulse, full timeout after recovery
    c = cyc; mr_n = 1'b0;
    wait_cyc(5); mr_n = 1'b1;
    wait_cyc(5); supply_ok = 1'b0;
    expect_at(c + 13, 1'b1, "R7");
    expect_at(c + T + 6, 1'b1, "R7");
    wait_cyc(5); supply_ok = 1'b1;
    expect_at(c + 15 + T + 2, 1'b1, "R7");
    expect_at(c + 15 + T + 3, 1'b0, "R7");
    wait_cyc(T + 20);

    // R7: supply drop during lockout
    c = cyc; mr_n = 1'b0;
    wait_cyc(2); mr_n = 1'b1;
    wait_cyc(T + 3); supply_ok = 1'b0;
    expect_at(c + T + 7, 1'b0, "R7");
    expect_at(c + T + 8, 1'b1, "R7");
    wait_cyc(7); supply_ok = 1'b1;
    expect_at(c + T + 12 + T + 2, 1'b1, "R7");
    expect_at(c + T + 12 + T + 3, 1'b0, "R7");
    wait_cyc(T + 10);

    while (q.size() > 0) wait_cyc(1);
    wait_cyc(1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule